// File: doc/BRIEF.md
# Segmented Carry-Select Adder with Accumulator

This block adds two N-bit operands and a carry-in using carry-select arithmetic. The width is cut into 10-bit groups, and each group is cut into two 5-bit segments. Every bit position of a segment runs two carry chains side by side. One chain assumes the segment's incoming carry is 0 and the other assumes it is 1. The carry that really arrives at the segment then picks one chain's sum bits and carry-out. That picked carry is the select for the next segment, so a select point is formed after bit 5 and after bit 10 of every group. The carry-out of each group is the carry-in of the group above it, and the carry-out of the top bit leaves the block.

The result can leave the block in two ways. It can go straight out through the combinational adder, or it can come from an output register that is loaded on every clock edge. When accumulate mode is on, the registered sum takes the place of operand A, so the block adds B and the carry-in to a running total on each clock. A synchronous clear empties the accumulator.

Top module: `csa_accum_top`

## Requirements
- R1: `{cout, sum}` is the (N+1)-bit value A + B + cin. Bit N of that value is the carry-out. Bits 0 to N-1 are the sum.
- R2: A carry can run through every 5-bit segment boundary and every 10-bit group boundary. With A all ones, B zero and cin 1, the result is sum 0 and cout 1. Inside each segment, the carry-1 candidate `{co1,sum1}` always equals the carry-0 candidate `{co0,sum0}` plus one.
- R3: When `bypass` is 1, `sum` and `cout` show the combinational result of the present inputs in the same cycle.
- R4: When `bypass` is 0, `sum` and `cout` show the result of the inputs that were present at the previous rising clock edge.
- R5: When `acc_mode` is 1, the registered sum is used in place of input A, and the value on A has no effect. Each rising edge then loads registered sum + B + cin, and the registered carry becomes the carry-out of that addition.
- R6: When `clr` is 1 at a rising edge, the registered sum and the registered carry both become 0. Clear takes priority over accumulate mode.
- R7: While `rst_n` is 0, the registered sum and the registered carry are held at 0. This reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of the output register |
| acc_mode | input | 1 | 1: the registered sum replaces operand A |
| bypass | input | 1 | 1: combinational outputs; 0: registered outputs |
| a | input | N | Operand A |
| b | input | N | Operand B |
| cin | input | 1 | Carry into bit 0 |
| sum | output | N | Sum bits |
| cout | output | 1 | Carry out of bit N-1 |

## Verification
In bypass mode the result is due in the same cycle. The bench drives the inputs at the falling edge and checks the outputs a few nanoseconds later, before any rising edge comes. In registered mode, and for every clear and accumulate step, the result is due one rising edge later. The bench therefore drives at one falling edge and checks at the next falling edge, when exactly one register load has taken place. The expected values come from a bitwise full-adder model inside the bench, and for accumulation from a running total that the bench keeps itself.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int SEG_W = 5;
  localparam int GRP_W = 10;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (x & c) | (y & c);
  endfunction
endpackage

// File: rtl/csa_segment.sv
module csa_segment
  import csa_pkg::*;
#(
  parameter int W = SEG_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum0,
  output logic [W-1:0] sum1,
  output logic         co0,
  output logic         co1
);
  logic [W:0] chain0;
  logic [W:0] chain1;

  always_comb begin
    chain0[0] = 1'b0;
    chain1[0] = 1'b1;
    for (int i = 0; i < W; i++) begin
      sum0[i]     = fa_sum(a[i], b[i], chain0[i]);
      sum1[i]     = fa_sum(a[i], b[i], chain1[i]);
      chain0[i+1] = fa_carry(a[i], b[i], chain0[i]);
      chain1[i+1] = fa_carry(a[i], b[i], chain1[i]);
    end
    co0 = chain0[W];
    co1 = chain1[W];
    // R2: the carry-1 candidate is always one above the carry-0 candidate
    assert_cand_step_R2: assert ({co1, sum1} == {co0, sum0} + (W+1)'(1));
  end
endmodule

// File: rtl/csa_group.sv
module csa_group
  import csa_pkg::*;
#(
  parameter int W   = GRP_W,
  parameter int SW  = SEG_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int NSEG = W / SW;

  logic [NSEG:0]   sel;
  logic [NSEG-1:0] seg_co0;
  logic [NSEG-1:0] seg_co1;

  assign sel[0] = cin;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    logic [SW-1:0] s0;
    logic [SW-1:0] s1;
    csa_segment #(.W(SW)) seg_i (
      .a   (a[s*SW +: SW]),
      .b   (b[s*SW +: SW]),
      .sum0(s0),
      .sum1(s1),
      .co0 (seg_co0[s]),
      .co1 (seg_co1[s])
    );
    assign sum[s*SW +: SW] = sel[s] ? s1 : s0;
    assign sel[s+1]        = sel[s] ? seg_co1[s] : seg_co0[s];
  end

  assign cout = sel[NSEG];
endmodule

// File: rtl/csa_accum_top.sv
module csa_accum_top
  import csa_pkg::*;
#(
  parameter int N = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         acc_mode,
  input  logic         bypass,
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  localparam int NGRP  = (N + GRP_W - 1) / GRP_W;
  localparam int PAD_W = NGRP * GRP_W;

  logic [N-1:0]     sum_q;
  logic             cout_q;
  logic [N-1:0]     op_a;
  logic [PAD_W-1:0] a_pad;
  logic [PAD_W-1:0] b_pad;
  logic [PAD_W-1:0] pad_sum;
  logic [NGRP:0]    gcarry;
  logic [N-1:0]     add_sum;
  logic             add_cout;

  assign op_a  = acc_mode ? sum_q : a;
  assign a_pad = PAD_W'(op_a);
  assign b_pad = PAD_W'(b);
  assign gcarry[0] = cin;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    csa_group #(.W(GRP_W), .SW(SEG_W)) grp_i (
      .a   (a_pad[g*GRP_W +: GRP_W]),
      .b   (b_pad[g*GRP_W +: GRP_W]),
      .cin (gcarry[g]),
      .sum (pad_sum[g*GRP_W +: GRP_W]),
      .cout(gcarry[g+1])
    );
  end

  if (PAD_W == N) begin : g_full
    assign add_sum  = pad_sum;
    assign add_cout = gcarry[NGRP];
  end else begin : g_part
    assign add_sum  = pad_sum[N-1:0];
    assign add_cout = pad_sum[N];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else if (clr) begin
      sum_q  <= '0;
      cout_q <= 1'b0;
    end else begin
      sum_q  <= add_sum;
      cout_q <= add_cout;
    end
  end

  assign sum  = bypass ? add_sum  : sum_q;
  assign cout = bypass ? add_cout : cout_q;

  // R1 / R3: the segmented chains agree with a plain addition
  assert_comb_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> {add_cout, add_sum} == ({1'b0, op_a} + {1'b0, b} + (N+1)'(cin)));

  // R4: without clear or accumulate, the register holds last edge's A+B+cin
  assert_reg_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !acc_mode) |=> {cout_q, sum_q} == ($past({1'b0, a}) + $past({1'b0, b}) + (N+1)'($past(cin))));

  // R5: accumulation adds B and cin to the previous total
  assert_accum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && acc_mode) |=> {cout_q, sum_q} == ($past({1'b0, sum_q}) + $past({1'b0, b}) + (N+1)'($past(cin))));

  // R6: clear empties the register whatever the mode
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_q == '0 && !cout_q));
endmodule

// File: tb/csa_accum_top_tb_top.sv
module csa_accum_top_tb_top;
  localparam int N = 30;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         clr = 1'b0;
  logic         acc_mode = 1'b0;
  logic         bypass = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic         cin = 1'b0;
  logic [N-1:0] sum;
  logic         cout;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  csa_accum_top #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .acc_mode(acc_mode), .bypass(bypass),
    .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  // stimulus table: {a, b, cin}
  localparam int NV = 10;
  localparam logic [2*N:0] VEC [NV] = '{
    {30'h00000000, 30'h00000000, 1'b0},
    {30'h3FFFFFFF, 30'h00000000, 1'b1},
    {30'h3FFFFFFF, 30'h3FFFFFFF, 1'b1},
    {30'h0000001F, 30'h00000000, 1'b1},
    {30'h000003FF, 30'h00000000, 1'b1},
    {30'h15555555, 30'h2AAAAAAA, 1'b1},
    {30'h2AAAAAAA, 30'h15555555, 1'b0},
    {30'h12345678, 30'h0ABCDEF0, 1'b0},
    {30'h20000000, 30'h20000000, 1'b0},
    {30'h0000FFFF, 30'h00000001, 1'b0}
  };

  // bench model: serial full-adder walk, written independently of the RTL
  function automatic logic [N:0] ref_add(input logic [N-1:0] x, input logic [N-1:0] y, input logic c);
    logic [N:0] r;
    logic k;
    k = c;
    for (int i = 0; i < N; i++) begin
      r[i] = x[i] ^ y[i] ^ k;
      k    = (x[i] && y[i]) || (k && (x[i] ^ y[i]));
    end
    r[N] = k;
    return r;
  endfunction

  task automatic check(input string req, input logic [N:0] exp_v);
    total++;
    if ({cout, sum} !== exp_v) begin
      bad++;
      $display("FAIL %s: got cout=%0b sum=%h, want cout=%0b sum=%h",
               req, cout, sum, exp_v[N], exp_v[N-1:0]);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N:0] acc;
    logic [N-1:0] step_b;

    // R7: reset holds the register at zero
    @(negedge clk);
    a = 30'h3FFFFFFF; b = 30'h3FFFFFFF; cin = 1'b1;
    @(negedge clk);
    check("R7", '0);
    rst_n = 1'b1;

    // table walk, once combinational (R1/R3), once registered (R1/R4)
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {a, b, cin} = VEC[v];
      bypass = 1'b1;
      #2;
      check("R3", ref_add(VEC[v][2*N:N+1], VEC[v][N:1], VEC[v][0]));
      bypass = 1'b0;
      @(negedge clk);
      check("R4", ref_add(VEC[v][2*N:N+1], VEC[v][N:1], VEC[v][0]));
    end

    // R2: full-width propagate in both output paths
    @(negedge clk);
    a = '1; b = '0; cin = 1'b1; bypass = 1'b1;
    #2;
    check("R2", {1'b1, {N{1'b0}}});
    bypass = 1'b0;
    @(negedge clk);
    check("R2", {1'b1, {N{1'b0}}});

    // random operands, both paths (R1)
    for (int r = 0; r < 20; r++) begin
      @(negedge clk);
      a = N'($urandom); b = N'($urandom); cin = 1'($urandom);
      bypass = 1'b1;
      #2;
      check("R1", ref_add(a, b, cin));
      bypass = 1'b0;
      @(negedge clk);
      check("R1", ref_add(a, b, cin));
      a = N'($urandom);
    end

    // R6: clear
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    check("R6", '0);

    // R5: accumulate, A scrambled each step to show it is ignored
    clr = 1'b0; acc_mode = 1'b1; step_b = 30'h2AAAAAAA; b = step_b; cin = 1'b0;
    acc = '0;
    for (int s = 0; s < 5; s++) begin
      a = N'($urandom);
      @(negedge clk);
      acc = ref_add(acc[N-1:0], step_b, 1'b0);
      check("R5", acc);
    end

    // R5 with carry-in and combinational view of next total
    cin = 1'b1;
    bypass = 1'b1;
    #2;
    check("R5", ref_add(acc[N-1:0], step_b, 1'b1));
    bypass = 1'b0;
    @(negedge clk);
    acc = ref_add(acc[N-1:0], step_b, 1'b1);
    check("R5", acc);

    // R6: clear wins over accumulate
    clr = 1'b1;
    @(negedge clk);
    check("R6", '0);
    clr = 1'b0; acc_mode = 1'b0;

    // R7: asynchronous reset mid-run
    a = 30'h0F0F0F0F; b = 30'h01010101; cin = 1'b0;
    @(negedge clk);
    check("R4", ref_add(30'h0F0F0F0F, 30'h01010101, 1'b0));
    #2;
    rst_n = 1'b0;
    #1;
    check("R7", '0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule